// File: doc/BRIEF.md
# Bidirectional raster scan sequencer

This block walks a two-axis scan grid and collects one sample from every selected ADC channel at each grid point. A host sets up the scan through a small register file: points per line, line count, settle delay, signed X and Y step sizes and a channel-enable mask. The host then writes the start bit. From that point the block drives the X and Y DAC codes. After every point it waits out the settle delay, triggers the enabled converters together, and passes the returned 24-bit samples one at a time to a downstream memory writer.

Each line is traversed twice. The forward pass adds the X step at every point. The return pass retraces the same points in the opposite order and ends back at X = 0. The Y coordinate then advances by the Y step. The converters and the DACs are outside the block. Only their trigger/finish handshake and the DAC codes appear at the ports.

Top module: `raster_scan_seq`

## Requirements
- R1: After reset every register reads zero, `running`, `cmd_done`, `out_valid` are low and `adc_arm` is zero.
- R2: A register access holds `cmd_ready` high. `cmd_done` rises one cycle after `cmd_ready` and falls one cycle after it drops. `cmd_code[3]` set means write, and `cmd_code[2:0]` selects 0 points per line, 1 line count, 2 settle cycles, 3 X step, 4 Y step, 5 channel mask, 6 start bit. `cmd_rdata` returns the register value as it stood before the access, zero-extended, or sign-extended for the two steps. A read leaves the register unchanged.
- R3: While a scan is in progress, writes to registers 0 to 5 are ignored and the start bit reads 1.
- R4: `adc_arm` is either zero or exactly the channel mask. Once raised it holds until `adc_done` equals it. It is not raised again while `adc_done` is nonzero.
- R5: `adc_arm` rises no sooner than settle+1 cycles after the last change of `dac_x` or `dac_y`.
- R6: Line l has Y = l·dy. Forward point c sits at X = c·dx, and return point c at X = (N−1−c)·dx, where N is the number of points per line. All coordinates wrap to 16 bits.
- R7: Each point's samples leave in ascending channel order and only for enabled channels. Each item carries the value the converter gave at capture. An item that is not accepted holds steady.
- R8: A frame delivers N × lines × (enabled channel count) × 2 items. `running` stays high until after the last one is accepted, and the start bit then reads 0.
- R9: Starting with zero points or zero lines ends the frame at once with no output. A zero mask runs the scan and produces no output and no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ready | input | 1 | Host request, held until `cmd_done` |
| cmd_code | input | 4 | Bit 3 write flag, bits 2:0 register select |
| cmd_wdata | input | 32 | Write data |
| cmd_done | output | 1 | Access acknowledged |
| cmd_rdata | output | 32 | Register value for the access |
| dac_x | output | 16 | Signed X DAC code |
| dac_y | output | 16 | Signed Y DAC code |
| adc_arm | output | 9 | Per-channel converter trigger |
| adc_done | input | 9 | Per-channel converter finished |
| adc_sample | input | 216 | Channel i sample at bits [24i+23:24i] |
| out_valid | output | 1 | Output item available |
| out_ready | input | 1 | Downstream accepts the item |
| out_chan | output | 4 | Channel index of the item |
| out_data | output | 24 | Sample value |
| running | output | 1 | Scan in progress |

## Verification
The register response is due exactly one cycle after `cmd_ready` rises. The acknowledge clears exactly one cycle after `cmd_ready` falls. The bench samples both on the next falling edge. Scan timing is not fixed, so the bench does not predict cycles for items. It keeps a queue of expected (channel, sample, X, Y) items, computed from the grid formula, and compares the head on the falling edge before each accepting rising edge. Trigger timing is checked against a count of falling edges since the last DAC change, which must reach settle+1. The end of a frame is confirmed by waiting for `running` to fall and then reading the start bit.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned CMD_W  = 4;
  localparam int unsigned WR_BIT = 3;

  typedef enum logic [2:0] {
    REG_POINTS = 3'd0,
    REG_LINES  = 3'd1,
    REG_SETTLE = 3'd2,
    REG_STEPX  = 3'd3,
    REG_STEPY  = 3'd4,
    REG_MASK   = 3'd5,
    REG_START  = 3'd6
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ARM,
    ST_SEND,
    ST_STEP
  } scan_st_e;

  // index of the lowest set bit, zero when none is set
  function automatic logic [4:0] lowest_one(input logic [31:0] m);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--)
      if (m[i]) r = i[4:0];
    return r;
  endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SET_W = 16,
  parameter int unsigned DAC_W = 16,
  parameter int unsigned NADC  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_ready,
  input  logic [CMD_W-1:0]        cmd_code,
  input  logic [31:0]             cmd_wdata,
  output logic                    cmd_done,
  output logic [31:0]             cmd_rdata,
  input  logic                    frame_end,
  output logic [CNT_W-1:0]        points_q,
  output logic [CNT_W-1:0]        lines_q,
  output logic [SET_W-1:0]        settle_q,
  output logic signed [DAC_W-1:0] dx_q,
  output logic signed [DAC_W-1:0] dy_q,
  output logic [NADC-1:0]         mask_q,
  output logic                    start_q
);

  logic     take;
  logic     wr_en;
  logic     cfg_wr;
  reg_sel_e sel;
  logic [31:0] rd_val;

  assign take   = cmd_ready && !cmd_done;
  assign wr_en  = take && cmd_code[WR_BIT];
  assign cfg_wr = wr_en && !start_q;
  assign sel    = reg_sel_e'(cmd_code[2:0]);

  always_comb begin
    case (sel)
      REG_POINTS: rd_val = 32'(points_q);
      REG_LINES:  rd_val = 32'(lines_q);
      REG_SETTLE: rd_val = 32'(settle_q);
      REG_STEPX:  rd_val = {{(32-DAC_W){dx_q[DAC_W-1]}}, dx_q};
      REG_STEPY:  rd_val = {{(32-DAC_W){dy_q[DAC_W-1]}}, dy_q};
      REG_MASK:   rd_val = 32'(mask_q);
      REG_START:  rd_val = 32'(start_q);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_done  <= 1'b0;
      cmd_rdata <= '0;
      points_q  <= '0;
      lines_q   <= '0;
      settle_q  <= '0;
      dx_q      <= '0;
      dy_q      <= '0;
      mask_q    <= '0;
      start_q   <= 1'b0;
    end else begin
      cmd_done <= cmd_ready;
      if (take) cmd_rdata <= rd_val;
      if (cfg_wr) begin
        case (sel)
          REG_POINTS: points_q <= cmd_wdata[CNT_W-1:0];
          REG_LINES:  lines_q  <= cmd_wdata[CNT_W-1:0];
          REG_SETTLE: settle_q <= cmd_wdata[SET_W-1:0];
          REG_STEPX:  dx_q     <= cmd_wdata[DAC_W-1:0];
          REG_STEPY:  dy_q     <= cmd_wdata[DAC_W-1:0];
          REG_MASK:   mask_q   <= cmd_wdata[NADC-1:0];
          default: ;
        endcase
      end
      if (frame_end)
        start_q <= 1'b0;
      else if (wr_en && sel == REG_START && !start_q)
        start_q <= cmd_wdata[0];
    end
  end

endmodule

// File: rtl/raster_settle.sv
module raster_settle #(
  parameter int unsigned SET_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SET_W-1:0] limit,
  output logic             elapsed
);

  logic [SET_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (cnt != '1)
      cnt <= cnt + SET_W'(1);
  end

  assign elapsed = (cnt >= limit);

endmodule

// File: rtl/raster_drain.sv
module raster_drain
  import raster_pkg::*;
#(
  parameter int unsigned NADC = 9,
  parameter int unsigned SW   = 24,
  parameter int unsigned CH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NADC-1:0]    mask,
  input  logic [NADC*SW-1:0] samples,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [CH_W-1:0]    out_chan,
  output logic [SW-1:0]      out_data,
  output logic               empty
);

  logic [NADC-1:0] pend;
  logic [SW-1:0]   held [NADC];

  assign out_chan  = CH_W'(lowest_one(32'(pend)));
  assign out_valid = (pend != '0);
  assign empty     = (pend == '0);

  always_comb begin
    out_data = '0;
    for (int i = 0; i < NADC; i++)
      if (out_chan == CH_W'(i)) out_data = held[i];
  end

  for (genvar g = 0; g < NADC; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)    held[g] <= '0;
      else if (load) held[g] <= samples[g*SW +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= '0;
    else if (load)
      pend <= mask;
    else if (out_valid && out_ready)
      pend <= pend & ~(NADC'(1) << out_chan);
  end

endmodule

// File: rtl/raster_scan_seq.sv
module raster_scan_seq
  import raster_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SET_W = 16,
  parameter int unsigned DAC_W = 16,
  parameter int unsigned NADC  = 9,
  parameter int unsigned SW    = 24,
  localparam int unsigned CH_W = (NADC > 1) ? $clog2(NADC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_ready,
  input  logic [CMD_W-1:0]        cmd_code,
  input  logic [31:0]             cmd_wdata,
  output logic                    cmd_done,
  output logic [31:0]             cmd_rdata,
  output logic signed [DAC_W-1:0] dac_x,
  output logic signed [DAC_W-1:0] dac_y,
  output logic [NADC-1:0]         adc_arm,
  input  logic [NADC-1:0]         adc_done,
  input  logic [NADC*SW-1:0]      adc_sample,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CH_W-1:0]         out_chan,
  output logic [SW-1:0]           out_data,
  output logic                    running
);

  function automatic logic signed [DAC_W-1:0] nudge(
    input logic signed [DAC_W-1:0] p,
    input logic signed [DAC_W-1:0] d,
    input logic back);
    return back ? p - d : p + d;
  endfunction

  logic [CNT_W-1:0]        points_q, lines_q;
  logic [SET_W-1:0]        settle_q;
  logic signed [DAC_W-1:0] dx_q, dy_q;
  logic [NADC-1:0]         mask_q;
  logic                    start_q;

  scan_st_e         st;
  logic [CNT_W-1:0] col, line;
  logic             fwd;
  logic [NADC-1:0]  arm_r;

  // named events between the pieces
  logic start_ok, start_empty, settled, captured;
  logic last_col, last_line, frame_end, restart;
  logic settle_elapsed, drain_empty;

  assign start_ok    = (st == ST_IDLE) && start_q && points_q != '0 && lines_q != '0;
  assign start_empty = (st == ST_IDLE) && start_q && (points_q == '0 || lines_q == '0);
  assign settled     = (st == ST_SETTLE) && settle_elapsed && adc_done == '0;
  assign captured    = (st == ST_ARM) && adc_done == arm_r;
  assign last_col    = (col == points_q - CNT_W'(1));
  assign last_line   = (line == lines_q - CNT_W'(1));
  assign frame_end   = start_empty || ((st == ST_STEP) && !fwd && last_col && last_line);
  assign restart     = start_ok || ((st == ST_STEP) && !frame_end);

  assign running = start_q;
  assign adc_arm = arm_r;

  raster_regs #(.CNT_W(CNT_W), .SET_W(SET_W), .DAC_W(DAC_W), .NADC(NADC)) u_regs (
    .clk, .rst_n, .cmd_ready, .cmd_code, .cmd_wdata, .cmd_done, .cmd_rdata,
    .frame_end, .points_q, .lines_q, .settle_q, .dx_q, .dy_q, .mask_q, .start_q
  );

  raster_settle #(.SET_W(SET_W)) u_settle (
    .clk, .rst_n, .restart, .limit(settle_q), .elapsed(settle_elapsed)
  );

  raster_drain #(.NADC(NADC), .SW(SW), .CH_W(CH_W)) u_drain (
    .clk, .rst_n, .load(captured), .mask(mask_q), .samples(adc_sample),
    .out_ready, .out_valid, .out_chan, .out_data, .empty(drain_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      col   <= '0;
      line  <= '0;
      fwd   <= 1'b1;
      dac_x <= '0;
      dac_y <= '0;
      arm_r <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_ok) begin
          dac_x <= '0;
          dac_y <= '0;
          col   <= '0;
          line  <= '0;
          fwd   <= 1'b1;
          st    <= ST_SETTLE;
        end
        ST_SETTLE: if (settled) begin
          arm_r <= mask_q;
          st    <= ST_ARM;
        end
        ST_ARM: if (captured) begin
          arm_r <= '0;
          st    <= ST_SEND;
        end
        ST_SEND: if (drain_empty) st <= ST_STEP;
        ST_STEP: begin
          if (frame_end) begin
            st <= ST_IDLE;
          end else begin
            st <= ST_SETTLE;
            if (last_col) begin
              col <= '0;
              if (fwd) begin
                fwd <= 1'b0;
              end else begin
                fwd   <= 1'b1;
                line  <= line + CNT_W'(1);
                dac_y <= nudge(dac_y, dy_q, 1'b0);
              end
            end else begin
              col   <= col + CNT_W'(1);
              dac_x <= nudge(dac_x, dx_q, !fwd);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/raster_scan_chk.sv
module raster_scan_chk #(
  parameter int unsigned SET_W = 16,
  parameter int unsigned DAC_W = 16,
  parameter int unsigned NADC  = 9,
  parameter int unsigned SW    = 24,
  parameter int unsigned CH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             cmd_done,
  input logic [DAC_W-1:0] dac_x,
  input logic [DAC_W-1:0] dac_y,
  input logic [NADC-1:0]  adc_arm,
  input logic [NADC-1:0]  adc_done,
  input logic [NADC-1:0]  mask_q,
  input logic [SET_W-1:0] settle_q,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CH_W-1:0]  out_chan,
  input logic [SW-1:0]    out_data,
  input logic             running
);

  logic [31:0]      gap;
  logic [DAC_W-1:0] px, py;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '1;
      px  <= '0;
      py  <= '0;
    end else begin
      px <= dac_x;
      py <= dac_y;
      if (dac_x != px || dac_y != py) gap <= '0;
      else if (gap != '1)             gap <= gap + 32'd1;
    end
  end

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_done) |=> cmd_done);

  // R4
  arm_equals_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_arm != '0) |-> (adc_arm == mask_q));

  // R4
  arm_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_arm != '0 && adc_done != adc_arm) |=> (adc_arm == $past(adc_arm)));

  // R4
  arm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_arm == '0 && $past(adc_arm) != '0) |-> ($past(adc_done) == $past(adc_arm)));

  // R4
  arm_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_arm != '0 && $past(adc_arm) == '0) |-> ($past(adc_done) == '0));

  // R5
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_arm != '0 && $past(adc_arm) == '0) |-> (gap >= 32'(settle_q)));

  // R7
  item_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_data)));

  // R7
  item_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((mask_q >> out_chan) & NADC'(1)) != '0));

  // R8
  item_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> running);

endmodule

bind raster_scan_seq raster_scan_chk #(
  .SET_W(SET_W), .DAC_W(DAC_W), .NADC(NADC), .SW(SW), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
  .dac_x(dac_x), .dac_y(dac_y), .adc_arm(adc_arm), .adc_done(adc_done),
  .mask_q(mask_q), .settle_q(settle_q), .out_valid(out_valid),
  .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data),
  .running(running)
);

// File: tb/tb_raster_scan_seq.sv
module tb_raster_scan_seq;
  import raster_pkg::*;

  localparam int NADC  = 9;
  localparam int SW    = 24;
  localparam int DAC_W = 16;
  localparam int CH_W  = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic cmd_ready;
  logic [3:0] cmd_code;
  logic [31:0] cmd_wdata, cmd_rdata;
  logic cmd_done;
  logic [DAC_W-1:0] dac_x, dac_y;
  logic [NADC-1:0] adc_arm, adc_done;
  logic [NADC*SW-1:0] adc_sample;
  logic out_valid, out_ready;
  logic [CH_W-1:0] out_chan;
  logic [SW-1:0] out_data;
  logic running;

  raster_scan_seq dut (
    .clk, .rst_n, .cmd_ready, .cmd_code, .cmd_wdata, .cmd_done, .cmd_rdata,
    .dac_x, .dac_y, .adc_arm, .adc_done, .adc_sample,
    .out_valid, .out_ready, .out_chan, .out_data, .running
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [CH_W-1:0]  ch;
    logic [SW-1:0]    d;
    logic [DAC_W-1:0] x;
    logic [DAC_W-1:0] y;
  } item_t;

  item_t expq[$];
  int adc_pt = 0;
  int recv = 0;
  int cur_settle = 0;
  logic [NADC-1:0] cur_mask = '0;
  bit throttle = 1'b0;

  function automatic logic [SW-1:0] smp(input int pt, input int ch);
    return SW'(pt * 40503 + ch * 911 + 17);
  endfunction

  // ---------------- register access ----------------
  task automatic xfer(input logic [3:0] code, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    cmd_code  = code;
    cmd_wdata = wd;
    cmd_ready = 1'b1;
    @(negedge clk);
    check(cmd_done === 1'b1, "R2", "ack one cycle after request", 64'(cmd_done), 1);
    rd = cmd_rdata;
    cmd_ready = 1'b0;
    @(negedge clk);
    check(cmd_done === 1'b0, "R2", "ack drops after request", 64'(cmd_done), 0);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] v);
    logic [31:0] dummy;
    xfer({1'b1, sel}, v, dummy);
  endtask

  task automatic rd_expect(input logic [2:0] sel, input logic [31:0] exp, input string req);
    logic [31:0] v;
    xfer({1'b0, sel}, 32'hA5A5_5A5A, v);
    check(v === exp, req, $sformatf("read of register %0d", sel), 64'(v), 64'(exp));
  endtask

  // ---------------- converter model ----------------
  initial begin
    adc_done   = '0;
    adc_sample = '0;
    forever begin
      @(negedge clk);
      if (adc_arm != '0 && adc_done == '0) begin
        repeat (adc_pt % 3) @(negedge clk);
        for (int ch = 0; ch < NADC; ch++)
          if (adc_arm[ch]) adc_sample[ch*SW +: SW] = smp(adc_pt, ch);
        adc_done = adc_arm;
        adc_pt++;
      end else if (adc_arm == '0 && adc_done != '0) begin
        adc_done = '0;
      end
    end
  end

  // ---------------- per-clock monitor and sink ----------------
  initial begin
    int gap = 0;
    int cyc = 0;
    logic [NADC-1:0] prev_arm = '0;
    logic [DAC_W-1:0] px = '0, py = '0;
    bit nr;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (dac_x !== px || dac_y !== py) gap = 0; else gap++;
        px = dac_x;
        py = dac_y;
        if (adc_arm != '0 && prev_arm == '0) begin
          check(gap >= cur_settle + 1, "R5", "settle cycles before trigger", 64'(gap), 64'(cur_settle + 1));
          check(adc_arm == cur_mask, "R4", "trigger equals mask", 64'(adc_arm), 64'(cur_mask));
        end
        prev_arm = adc_arm;
        if (out_valid && !running)
          check(1'b0, "R8", "item outside frame", 64'(running), 1);
        nr = throttle ? (cyc % 3 != 0) : 1'b1;
        out_ready = nr;
        if (out_valid && nr) begin
          if (expq.size() == 0) begin
            check(1'b0, "R8", "unexpected extra item", 64'(out_chan), 0);
          end else begin
            item_t e;
            e = expq.pop_front();
            check(out_chan == e.ch, "R7", "channel order", 64'(out_chan), 64'(e.ch));
            check(out_data == e.d, "R7", "sample value", 64'(out_data), 64'(e.d));
            check(dac_x == e.x, "R6", "X at sample", 64'(dac_x), 64'(e.x));
            check(dac_y == e.y, "R6", "Y at sample", 64'(dac_y), 64'(e.y));
            recv++;
          end
        end
      end
    end
  end

  // ---------------- frame helpers ----------------
  task automatic setup(input int pts, input int lns, input int st, input int dx,
                       input int dy, input logic [NADC-1:0] m);
    wr(3'(REG_POINTS), 32'(pts));
    wr(3'(REG_LINES), 32'(lns));
    wr(3'(REG_SETTLE), 32'(st));
    wr(3'(REG_STEPX), 32'(dx));
    wr(3'(REG_STEPY), 32'(dy));
    wr(3'(REG_MASK), 32'(m));
    cur_settle = st;
    cur_mask = m;
  endtask

  task automatic predict(input int pts, input int lns, input int dx, input int dy,
                         input logic [NADC-1:0] m);
    int pt = adc_pt;
    for (int l = 0; l < lns; l++)
      for (int dir = 0; dir < 2; dir++)
        for (int c = 0; c < pts; c++) begin
          item_t it;
          it.x = DAC_W'((dir == 0) ? c * dx : (pts - 1 - c) * dx);
          it.y = DAC_W'(l * dy);
          for (int ch = 0; ch < NADC; ch++)
            if (m[ch]) begin
              it.ch = CH_W'(ch);
              it.d  = smp(pt, ch);
              expq.push_back(it);
            end
          if (m != '0) pt++;
        end
  endtask

  task automatic finish_frame(input int total, input string req);
    int guard = 0;
    while (running && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    check(!running, "R8", "frame ends", 64'(running), 0);
    check(recv == total, req, "items in frame", 64'(recv), 64'(total));
    check(expq.size() == 0, "R8", "no items missing", 64'(expq.size()), 0);
    rd_expect(3'(REG_START), 32'd0, "R8");
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0;
    cmd_ready = 1'b0;
    cmd_code = '0;
    cmd_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(running === 1'b0, "R1", "running after reset", 64'(running), 0);
    check(adc_arm === '0, "R1", "trigger after reset", 64'(adc_arm), 0);
    check(out_valid === 1'b0, "R1", "valid after reset", 64'(out_valid), 0);
    check(cmd_done === 1'b0, "R1", "ack after reset", 64'(cmd_done), 0);
    for (int r = 0; r < 7; r++) rd_expect(3'(r), 32'd0, "R1");

    // R2 register write and read back, sign extension, width truncation
    setup(3, 2, 4, 5, -7, 9'b100101011);
    rd_expect(3'(REG_POINTS), 32'd3, "R2");
    rd_expect(3'(REG_SETTLE), 32'd4, "R2");
    rd_expect(3'(REG_STEPX), 32'd5, "R2");
    rd_expect(3'(REG_STEPY), 32'hFFFF_FFF9, "R2");
    rd_expect(3'(REG_MASK), 32'h12B, "R2");
    rd_expect(3'(REG_MASK), 32'h12B, "R2");   // the read above did not write

    // Frame A: throttled sink, writes during the scan
    throttle = 1'b1;
    recv = 0;
    predict(3, 2, 5, -7, 9'b100101011);
    wr(3'(REG_START), 32'd1);
    rd_expect(3'(REG_START), 32'd1, "R3");
    wr(3'(REG_POINTS), 32'd9);
    rd_expect(3'(REG_POINTS), 32'd3, "R3");
    wr(3'(REG_MASK), 32'd1);
    rd_expect(3'(REG_MASK), 32'h12B, "R3");
    finish_frame(3 * 2 * 5 * 2, "R8");

    // Frame B: all channels, zero settle, negative X step
    throttle = 1'b0;
    setup(4, 2, 0, -3, 2, 9'h1FF);
    recv = 0;
    predict(4, 2, -3, 2, 9'h1FF);
    wr(3'(REG_START), 32'd1);
    finish_frame(4 * 2 * 9 * 2, "R8");

    // Frame C: zero points ends at once with no output (R9)
    setup(0, 3, 2, 1, 1, 9'h00F);
    recv = 0;
    wr(3'(REG_START), 32'd1);
    check(running === 1'b0, "R9", "empty frame ends at once", 64'(running), 0);
    finish_frame(0, "R9");

    // Frame D: zero mask scans without triggers or output (R9)
    setup(2, 2, 3, 1, 1, 9'h000);
    recv = 0;
    wr(3'(REG_START), 32'd1);
    check(running === 1'b1, "R9", "masked-off frame runs", 64'(running), 1);
    finish_frame(0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule